// File: doc/BRIEF.md
# Superpage and Cacheability Address Fixup

This stage sits directly behind the address translation unit and settles the final physical address of one access, with no clock and no storage. It recognises the kernel-only direct-mapped window of the virtual address space, where the physical address is formed from the low virtual bits with a sign extension on bit 40. Otherwise it takes the physical address from a bypass (physical mode) or from the translation result.

The resolved address is then classified. Bits above the 44-bit implemented range cause a machine check. Bit 43 marks an uncacheable access, and bits 42:35 are stripped from the outgoing address. An uncacheable address that lands in the internal-register window, or an uncacheable instruction fetch, raises an unimplemented fault. At most one fault output is high at a time.

Top module: `sp_addr_fixup`

## Requirements
- R1: When `phys_mode` is 0 and `va[47:41]` equals 7'h7e, the access is a superpage access. In kernel mode (`cpu_mode` = 2'b00) with `va[40]` = 0, `pa` equals `va[39:0]` zero-extended, and no fault is raised.
- R2: For a superpage access with `va[40]` = 1, bits 43:40 of the address are forced to ones before classification. The access therefore comes out uncacheable.
- R3: A superpage access with `cpu_mode` other than 2'b00 raises `flt_acv` and no other fault. `uncached` is then 0.
- R4: When `phys_mode` is 1, the address under classification is `va` itself. Superpage detection is off, so `flt_acv` stays 0 in every mode.
- R5: When neither bypass nor superpage applies, the address under classification is `xlat_pa`.
- R6: Any set bit in bits 63:44 of the address under classification raises `flt_mchk`. `uncached` is then 0.
- R7: With bit 43 set, no machine check or access violation, and the address outside the register window, `uncached` is 1. `pa` then has bits 42:35 cleared and every other bit kept.
- R8: The register window is an address with bit 43 set and bits 42:20 all ones. Such an access raises `flt_unimp`, leaves `uncached` at 0 and passes `pa` unchanged.
- R9: An uncacheable access with `ifetch` = 1 raises `flt_unimp`.
- R10: The fault outputs are one-hot or all zero. The priority is access violation, then machine check, then unimplemented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| va | input | 64 | Virtual address of the access |
| cpu_mode | input | 2 | Current processor mode, 2'b00 is kernel |
| ifetch | input | 1 | Access is an instruction fetch |
| phys_mode | input | 1 | Physical-mode bypass, address used untranslated |
| xlat_pa | input | 64 | Physical address from the translation unit |
| pa | output | 44 | Final physical address |
| uncached | output | 1 | Access must bypass the caches |
| flt_acv | output | 1 | Access violation |
| flt_mchk | output | 1 | Machine check on unimplemented physical bits |
| flt_unimp | output | 1 | Unimplemented register space or uncached fetch |

## Verification
Every output is a combinational function of the current inputs, so each result is due in the same cycle as its stimulus, with zero register stages. The driver applies one stimulus on a falling edge and queues its expected result. The monitor pops and compares that result at the next rising edge, half a period later, when the inputs have been stable since the driver applied them. No new stimulus arrives until the following falling edge, so each comparison sees exactly one stimulus.

// File: rtl/sp_addr_fixup.sv
module sp_addr_fixup #(
  parameter int VA_W    = 64,
  parameter int PA_W    = 44,
  parameter int SP_HI   = 47,
  parameter int SP_LO   = 41,
  parameter logic [SP_HI-SP_LO:0] SP_TAG = 7'h7e,
  parameter int EXT_BIT = 40,
  parameter int CLR_HI  = 42,
  parameter int CLR_LO  = 35,
  parameter int WIN_LSB = 20,
  parameter int MODE_W  = 2,
  parameter logic [MODE_W-1:0] KERNEL = '0
) (
  input  logic [VA_W-1:0]   va,
  input  logic [MODE_W-1:0] cpu_mode,
  input  logic              ifetch,
  input  logic              phys_mode,
  input  logic [VA_W-1:0]   xlat_pa,
  output logic [PA_W-1:0]   pa,
  output logic              uncached,
  output logic              flt_acv,
  output logic              flt_mchk,
  output logic              flt_unimp
);
  localparam int UC_BIT = PA_W - 1;
  localparam logic [PA_W-1:0] HI_ONES = {PA_W{1'b1}} << EXT_BIT;
  localparam logic [PA_W-1:0] CLR_MASK =
    ({PA_W{1'b1}} << CLR_LO) & ~({PA_W{1'b1}} << (CLR_HI + 1));

  logic            sp_hit;
  logic [PA_W-1:0] sp_pa;
  logic [VA_W-1:0] raw;
  logic            over, uc_bit, in_win, ok;

  assign sp_hit = !phys_mode && (va[SP_HI:SP_LO] == SP_TAG);
  assign sp_pa  = va[EXT_BIT] ? (va[PA_W-1:0] | HI_ONES) : (va[PA_W-1:0] & ~HI_ONES);

  always_comb begin
    if (phys_mode)   raw = va;
    else if (sp_hit) raw = {{(VA_W-PA_W){1'b0}}, sp_pa};
    else             raw = xlat_pa;
  end

  assign over   = |raw[VA_W-1:PA_W];
  assign uc_bit = raw[UC_BIT];
  assign in_win = &raw[UC_BIT-1:WIN_LSB];

  assign flt_acv   = sp_hit && (cpu_mode != KERNEL);
  assign flt_mchk  = !flt_acv && over;
  assign ok        = !flt_acv && !flt_mchk;
  assign flt_unimp = ok && uc_bit && (in_win || ifetch);
  assign uncached  = ok && uc_bit && !in_win;
  assign pa        = uncached ? (raw[PA_W-1:0] & ~CLR_MASK) : raw[PA_W-1:0];

  always_comb begin
    a_r10_fault_onehot: assert ($onehot0({flt_acv, flt_mchk, flt_unimp}));
    a_r3_acv_needs_user: assert (!flt_acv || (cpu_mode != KERNEL && !phys_mode));
    a_r4_bypass_no_acv: assert (!phys_mode || !flt_acv);
    a_r7_strip_field: assert (!uncached || (pa[UC_BIT] && (pa & CLR_MASK) == '0));
    a_r6_mchk_cached: assert (!flt_mchk || !uncached);
    if (sp_hit && cpu_mode == KERNEL && va[EXT_BIT])
      a_r2_ext_uncached: assert (uncached || flt_unimp);
  end
endmodule

// File: tb/sp_addr_fixup_bench.sv
module sp_addr_fixup_bench;
  typedef struct {
    logic [43:0] pa;
    logic        unc, acv, mchk, unimp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic [63:0] va, xlat_pa;
  logic [1:0]  cpu_mode;
  logic        ifetch, phys_mode;
  logic [43:0] pa;
  logic        uncached, flt_acv, flt_mchk, flt_unimp;
  item_t       q[$];
  int          checks = 0, errors = 0, cyc = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  sp_addr_fixup u_sp_addr_fixup (
    .va(va), .cpu_mode(cpu_mode), .ifetch(ifetch), .phys_mode(phys_mode),
    .xlat_pa(xlat_pa), .pa(pa), .uncached(uncached), .flt_acv(flt_acv),
    .flt_mchk(flt_mchk), .flt_unimp(flt_unimp)
  );

  always @(posedge clk) begin
    while (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      checks++;
      if (pa !== e.pa || uncached !== e.unc || flt_acv !== e.acv ||
          flt_mchk !== e.mchk || flt_unimp !== e.unimp) begin
        errors++;
        $display("FAIL %s: got pa=%h unc=%b acv=%b mchk=%b unimp=%b, expected pa=%h unc=%b acv=%b mchk=%b unimp=%b",
                 e.req, pa, uncached, flt_acv, flt_mchk, flt_unimp,
                 e.pa, e.unc, e.acv, e.mchk, e.unimp);
      end
    end
  end

  task automatic drive(input logic [63:0] v, input logic [1:0] m, input logic f,
                       input logic b, input logic [63:0] x, input logic [43:0] epa,
                       input logic eu, input logic ea, input logic em,
                       input logic ei, input string r);
    item_t e;
    @(negedge clk);
    va = v; cpu_mode = m; ifetch = f; phys_mode = b; xlat_pa = x;
    e.pa = epa; e.unc = eu; e.acv = ea; e.mchk = em; e.unimp = ei; e.req = r;
    q.push_back(e);
    @(posedge clk);
  endtask

  initial begin
    drive(64'h0, 2'b00, 0, 0, 64'h0, 44'h0, 0, 0, 0, 0, "R5 idle");
    drive(64'h1234, 2'b11, 0, 0, 64'h0123_4567_8000, 44'h123_4567_8000, 0, 0, 0, 0, "R5");
    drive(64'hFC00_1234_5678, 2'b00, 0, 0, 64'h0, 44'h0_0012_3456_78, 0, 0, 0, 0, "R1");
    drive(64'hFC00_1234_5678, 2'b00, 1, 0, 64'h0, 44'h0_0012_3456_78, 0, 0, 0, 0, "R1 fetch");
    drive(64'hFD00_0000_1ABC, 2'b00, 0, 0, 64'h0, 44'h800_0000_1ABC, 1, 0, 0, 0, "R2");
    drive(64'hFD00_0000_1ABC, 2'b00, 1, 0, 64'h0, 44'h800_0000_1ABC, 1, 0, 0, 1, "R2 R9");
    drive(64'hFC00_1234_5678, 2'b11, 0, 0, 64'h0, 44'h0_0012_3456_78, 0, 1, 0, 0, "R3");
    drive(64'hFD00_0000_1ABC, 2'b01, 1, 0, 64'h0, 44'hF00_0000_1ABC, 0, 1, 0, 0, "R3 R10");
    drive(64'hFC00_1234_5678, 2'b11, 0, 1, 64'h0, 44'hC00_1234_5678, 0, 0, 1, 0, "R4 R6");
    drive(64'h0AB_CDEF_0123, 2'b11, 0, 1, 64'h0, 44'h0AB_CDEF_0123, 0, 0, 0, 0, "R4");
    drive(64'h0, 2'b00, 0, 0, 64'h1000_0000_0000, 44'h0, 0, 0, 1, 0, "R6");
    drive(64'h0, 2'b00, 0, 0, 64'h087F_F123_4567, 44'h807_F123_4567, 1, 0, 0, 0, "R7");
    drive(64'h0, 2'b00, 0, 0, 64'h0FFF_FFF0_0040, 44'hFFF_FFF0_0040, 0, 0, 0, 1, "R8");
    drive(64'h0, 2'b00, 0, 0, 64'h0FFF_FFE0_0040, 44'h807_FFE0_0040, 1, 0, 0, 0, "R8 edge");
    drive(64'h0, 2'b00, 1, 0, 64'h087F_F123_4567, 44'h807_F123_4567, 1, 0, 0, 1, "R9");
    drive(64'h0, 2'b00, 1, 0, 64'h0123_4567_8000, 44'h123_4567_8000, 0, 0, 0, 0, "R9 cached");
    drive(64'h0, 2'b00, 1, 0, 64'h8000_0FFF_FFF0_0000, 44'hFFF_FFF0_0000, 0, 0, 1, 0, "R10");
    @(negedge clk);
    done = 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (done || cyc > 10000) begin
      if (!done) begin
        checks++; errors++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule